// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller with Critical Vectoring

This block gathers 32 interrupt request lines into two request outputs for a processor core: one for ordinary interrupts and one for critical interrupts. Each line can be set to latch on a rising edge or to follow its level. The latched status is gated by a per-source enable mask. A per-source critical-select mask then sends each enabled source to one of the two outputs.

Software programs the block through a simple word-wide register port. The port decodes nine consecutive word addresses starting at a fixed base. When vectoring is built in, the block also produces a vector address for the first pending critical source. That address is a programmable base plus a fixed 512-byte step for each priority position. One configuration bit chooses whether priority runs from status bit 0 upward or from bit 31 downward.

Top module: `irq_ctrl32`

## Requirements
- R1: Registers sit at word offsets from the base address: 0 status (write clears), 1 status (write sets), 2 enable, 3 critical select, 4 polarity, 5 trigger, 6 masked status, 7 vector, 8 vector config. Any other offset reads zero and ignores writes.
- R2: Input line n (irq_src_i[n]) drives status bit 31-n.
- R3: A source whose trigger bit is 1 is edge-sensitive. A rising input (high now, low on the previous clock) sets its status bit. A constant-high input sets the bit only once. A low input leaves the bit unchanged.
- R4: A source whose trigger bit is 0 is level-sensitive. On each input change, its status bit and a hidden level-memory bit take the input value. A write to offset 0 clears every status bit written as 1 and then ORs the level memory back in, so a held level cannot be cleared. A write to offset 1 ORs the data into status. Both offsets read the status.
- R5: irq_norm_o is high when (status & enable & ~critical) is nonzero. irq_crit_o is high when (status & enable & critical) is nonzero.
- R6: Offset 6 reads status & enable. Writes to offset 6 and offset 7 have no effect.
- R7: A write to offset 8 stores the data with bit 1 forced to 0. The vector equals the stored config with bits 1:0 cleared, plus 512 times the priority position of the first pending critical source.
- R8: With config bit 0 = 0, the scan starts at status bit 0 and the position equals the bit index. With config bit 0 = 1, the scan starts at bit 31 and the position equals 31 minus the index.
- R9: The vector reads zero when no critical source is pending. With parameter VEC_EN = 0, offsets 7 and 8 always read zero.
- R10: Reset clears enable, critical, polarity, status, trigger, vector config and vector. The polarity register is only stored and read back, and has no effect on the outputs.
- R11: The outputs and the vector change on the first clock edge after an input change or register write, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src_i | input | DATA_W | Interrupt request lines, line n maps to status bit DATA_W-1-n |
| reg_sel_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write enable, qualified by reg_sel_i |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, combinational from the addressed register |
| irq_norm_o | output | 1 | Ordinary interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |

## Verification
The bench builds two copies of the block on one shared register bus. Both use a nonzero base address of 0x0C0, so the offset decode is tested away from address zero. One copy has VEC_EN = 1, where vector arithmetic is checked in both scan directions and at positions 0, 15, 16 and 31. The other copy has VEC_EN = 0, so the zero reads of the vector registers can be compared while both copies raise the same critical request.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
// irqc_pkg: shared constants for the interrupt controller.
// Assumes a word-addressed register port with nine consecutive registers.
package irqc_pkg;
    localparam int OFS_W    = 4;
    localparam int NUM_REGS = 9;

    localparam logic [OFS_W-1:0] OFS_STAT_CLR = 4'd0;
    localparam logic [OFS_W-1:0] OFS_STAT_SET = 4'd1;
    localparam logic [OFS_W-1:0] OFS_ENABLE   = 4'd2;
    localparam logic [OFS_W-1:0] OFS_CRIT     = 4'd3;
    localparam logic [OFS_W-1:0] OFS_POLAR    = 4'd4;
    localparam logic [OFS_W-1:0] OFS_TRIG     = 4'd5;
    localparam logic [OFS_W-1:0] OFS_MASKED   = 4'd6;
    localparam logic [OFS_W-1:0] OFS_VECTOR   = 4'd7;
    localparam logic [OFS_W-1:0] OFS_VCFG     = 4'd8;
endpackage

// File: rtl/irqc_status.sv
`timescale 1ns/1ps
// irqc_status: per-bit status latch for edge- and level-sensitive sources.
// Assumes src_i is already in status-bit order. Register writes apply first,
// then the input event of the same cycle. Exposes the next-state value so the
// parent can register outputs with one cycle of latency.
module irqc_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] trig_i,
    input  logic         clr_we_i,
    input  logic         set_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] st_nxt_o,
    output logic [W-1:0] st_q_o
);
    logic [W-1:0] st_q, lvl_q, prev_q;
    logic [W-1:0] lvl_nxt;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            logic s_b, l_b;
            // Next status and level memory for one source.
            always_comb begin
                s_b = st_q[i];
                l_b = lvl_q[i];
                if (clr_we_i) s_b = (s_b & ~wdata_i[i]) | l_b;
                if (set_we_i) s_b = s_b | wdata_i[i];
                if (trig_i[i]) begin
                    if (src_i[i] && !prev_q[i]) s_b = 1'b1;
                end else if (src_i[i] != prev_q[i]) begin
                    s_b = src_i[i];
                    l_b = src_i[i];
                end
            end
            assign st_nxt_o[i] = s_b;
            assign lvl_nxt[i]  = l_b;
        end
    endgenerate

    // State registers: status, level memory and previous input sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            st_q   <= st_nxt_o;
            lvl_q  <= lvl_nxt;
            prev_q <= src_i;
        end
    end

    assign st_q_o = st_q;

    // R4: a set level-memory bit always keeps its status bit set.
    p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q & ~st_q) == '0);

    // R3: an edge source held high without a write keeps its status bit.
    p_edge_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we_i && !set_we_i) |=>
        ((st_q ^ $past(st_q)) & $past(trig_i & src_i & prev_q)) == '0);
endmodule

// File: rtl/irqc_vector.sv
`timescale 1ns/1ps
// irqc_vector: finds the first pending critical source in the selected scan
// direction and forms base + position * 2**STRIDE_SH. Purely combinational.
// Gives zero when nothing is pending.
module irqc_vector #(
    parameter int W         = 32,
    parameter int STRIDE_SH = 9
) (
    input  logic [W-1:0] pend_i,
    input  logic [W-3:0] base_i,
    input  logic         dir_i,
    output logic [W-1:0] vec_o
);
    localparam int POS_W = $clog2(W);

    logic [W-1:0]     scan;
    logic [POS_W-1:0] pos;
    logic             found;

    genvar k;
    generate
        for (k = 0; k < W; k++) begin : g_scan
            assign scan[k] = dir_i ? pend_i[W-1-k] : pend_i[k];
        end
    endgenerate

    // Lowest set bit of the scan-ordered vector gives the priority position.
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int j = W - 1; j >= 0; j--) begin
            if (scan[j]) begin
                found = 1'b1;
                pos   = POS_W'(j);
            end
        end
    end

    // Vector address from base and position.
    always_comb begin
        if (found) vec_o = {base_i, 2'b00} + (W'(pos) << STRIDE_SH);
        else       vec_o = '0;
    end
endmodule

// File: rtl/irq_ctrl32.sv
`timescale 1ns/1ps
// irq_ctrl32: interrupt controller top. Decodes the register window, keeps
// the mask and mode registers, and registers the two request outputs and the
// critical vector from next-state values, giving one clock of latency.
// Assumes DATA_W sources (one per status bit) and single-cycle register
// writes. Read data is combinational.
module irq_ctrl32 #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 10,
    parameter int BASE_ADDR = 'h0C0,
    parameter bit VEC_EN    = 1'b1,
    parameter int STRIDE_SH = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] irq_src_i,
    input  logic              reg_sel_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_norm_o,
    output logic              irq_crit_o
);
    import irqc_pkg::*;

    localparam int NUM_SRC = DATA_W;

    logic [ADDR_W-1:0] rel;
    logic [OFS_W-1:0]  ofs;
    logic              hit, wr;
    logic [NUM_SRC-1:0] src_map;
    logic [DATA_W-1:0] en_q, crit_q, pol_q, trig_q, vcfg_q, vec_q;
    logic [DATA_W-1:0] en_nxt, crit_nxt;
    logic [DATA_W-1:0] st_q, st_nxt;
    logic              norm_q, critr_q;

    // Window decode relative to the base address.
    assign rel = reg_addr_i - ADDR_W'(BASE_ADDR);
    assign hit = reg_sel_i && (reg_addr_i >= ADDR_W'(BASE_ADDR))
                 && (rel < ADDR_W'(NUM_REGS));
    assign ofs = rel[OFS_W-1:0];
    assign wr  = hit && reg_we_i;

    // Line n drives status bit NUM_SRC-1-n.
    genvar n;
    generate
        for (n = 0; n < NUM_SRC; n++) begin : g_map
            assign src_map[n] = irq_src_i[NUM_SRC-1-n];
        end
    endgenerate

    irqc_status #(.W(NUM_SRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_map),
        .trig_i   (trig_q),
        .clr_we_i (wr && ofs == OFS_STAT_CLR),
        .set_we_i (wr && ofs == OFS_STAT_SET),
        .wdata_i  (reg_wdata_i),
        .st_nxt_o (st_nxt),
        .st_q_o   (st_q)
    );

    assign en_nxt   = (wr && ofs == OFS_ENABLE) ? reg_wdata_i : en_q;
    assign crit_nxt = (wr && ofs == OFS_CRIT)   ? reg_wdata_i : crit_q;

    // Mode and mask registers plus registered request outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            crit_q  <= '0;
            pol_q   <= '0;
            trig_q  <= '0;
            norm_q  <= 1'b0;
            critr_q <= 1'b0;
        end else begin
            en_q    <= en_nxt;
            crit_q  <= crit_nxt;
            if (wr && ofs == OFS_POLAR) pol_q  <= reg_wdata_i;
            if (wr && ofs == OFS_TRIG)  trig_q <= reg_wdata_i;
            norm_q  <= |(st_nxt & en_nxt & ~crit_nxt);
            critr_q <= |(st_nxt & en_nxt & crit_nxt);
        end
    end

    generate
        if (VEC_EN) begin : g_vec
            logic [DATA_W-1:0] vcfg_nxt, vec_nxt;
            assign vcfg_nxt = (wr && ofs == OFS_VCFG)
                              ? (reg_wdata_i & ~DATA_W'(2)) : vcfg_q;

            irqc_vector #(.W(DATA_W), .STRIDE_SH(STRIDE_SH)) u_vector (
                .pend_i (st_nxt & en_nxt & crit_nxt),
                .base_i (vcfg_nxt[DATA_W-1:2]),
                .dir_i  (vcfg_nxt[0]),
                .vec_o  (vec_nxt)
            );

            // Vector configuration and computed vector registers.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vcfg_q <= '0;
                    vec_q  <= '0;
                end else begin
                    vcfg_q <= vcfg_nxt;
                    vec_q  <= vec_nxt;
                end
            end

            // R9: no critical request means a zero vector.
            p_vec_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !irq_crit_o |-> vec_q == '0);
        end else begin : g_novec
            assign vcfg_q = '0;
            assign vec_q  = '0;
        end
    endgenerate

    // Read multiplexer over the register window.
    always_comb begin
        reg_rdata_o = '0;
        if (hit) begin
            case (ofs)
                OFS_STAT_CLR, OFS_STAT_SET: reg_rdata_o = st_q;
                OFS_ENABLE: reg_rdata_o = en_q;
                OFS_CRIT:   reg_rdata_o = crit_q;
                OFS_POLAR:  reg_rdata_o = pol_q;
                OFS_TRIG:   reg_rdata_o = trig_q;
                OFS_MASKED: reg_rdata_o = st_q & en_q;
                OFS_VECTOR: reg_rdata_o = vec_q;
                OFS_VCFG:   reg_rdata_o = vcfg_q;
                default:    reg_rdata_o = '0;
            endcase
        end
    end

    assign irq_norm_o = norm_q;
    assign irq_crit_o = critr_q;

    // R5: outputs agree with the registered status, enable and select.
    p_norm_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_norm_o == |(st_q & en_q & ~crit_q));
    p_crit_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_crit_o == |(st_q & en_q & crit_q));
endmodule

// File: tb/irq_ctrl32_bench.sv
`timescale 1ns/1ps
// Bench: table-driven register tests, then directed input and reset tests.
module irq_ctrl32_bench;
    localparam int BASE = 'h0C0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        sel = 1'b0, we = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_nv;
    logic        norm, crit, norm_nv, crit_nv;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    irq_ctrl32 #(.BASE_ADDR(BASE), .VEC_EN(1'b1)) u_irq_ctrl32 (
        .clk(clk), .rst_n(rst_n), .irq_src_i(src), .reg_sel_i(sel),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_norm_o(norm), .irq_crit_o(crit));

    irq_ctrl32 #(.BASE_ADDR(BASE), .VEC_EN(1'b0)) u_irq_ctrl32_novec (
        .clk(clk), .rst_n(rst_n), .irq_src_i(src), .reg_sel_i(sel),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata_nv), .irq_norm_o(norm_nv), .irq_crit_o(crit_nv));

    // Row: req[77:74] wofs[73:70] wdata[69:38] rofs[37:34] exp[33:2] norm crit
    localparam int NROW = 18;
    localparam logic [77:0] TBL [0:NROW-1] = '{
        {4'd4, 4'd1, 32'h8000_0001, 4'd0, 32'h8000_0001, 1'b0, 1'b0}, // R4 set
        {4'd6, 4'd2, 32'h8000_0000, 4'd6, 32'h8000_0000, 1'b1, 1'b0}, // R6 masked
        {4'd7, 4'd3, 32'h8000_0000, 4'd7, 32'h0000_3E00, 1'b0, 1'b1}, // R7 pos 31
        {4'd7, 4'd8, 32'h1000_0003, 4'd8, 32'h1000_0001, 1'b0, 1'b1}, // R7 bit1 off
        {4'd8, 4'd7, 32'hFFFF_FFFF, 4'd7, 32'h1000_0000, 1'b0, 1'b1}, // R8 down, R6
        {4'd5, 4'd2, 32'h8000_0001, 4'd6, 32'h8000_0001, 1'b1, 1'b1}, // R5 both
        {4'd8, 4'd3, 32'h0000_0001, 4'd7, 32'h1000_3E00, 1'b1, 1'b1}, // R8 down
        {4'd8, 4'd8, 32'h2000_0000, 4'd7, 32'h2000_0000, 1'b1, 1'b1}, // R8 up
        {4'd5, 4'd3, 32'h8000_0001, 4'd3, 32'h8000_0001, 1'b0, 1'b1}, // R5
        {4'd9, 4'd2, 32'h0001_0000, 4'd7, 32'h0000_0000, 1'b0, 1'b0}, // R9 idle
        {4'd4, 4'd1, 32'h0001_0000, 4'd0, 32'h8001_0001, 1'b1, 1'b0}, // R4 set
        {4'd7, 4'd3, 32'h0001_0000, 4'd7, 32'h2000_2000, 1'b0, 1'b1}, // R7 pos 16
        {4'd8, 4'd8, 32'h0000_0001, 4'd7, 32'h0000_1E00, 1'b0, 1'b1}, // R8 pos 15
        {4'd4, 4'd0, 32'hFFFF_FFFF, 4'd0, 32'h0000_0000, 1'b0, 1'b0}, // R4 clear
        {4'd10,4'd4, 32'hA5A5_0000, 4'd4, 32'hA5A5_0000, 1'b0, 1'b0}, // R10 polarity
        {4'd6, 4'd6, 32'hFFFF_FFFF, 4'd6, 32'h0000_0000, 1'b0, 1'b0}, // R6 ignored
        {4'd1, 4'd5, 32'h0000_00FF, 4'd5, 32'h0000_00FF, 1'b0, 1'b0}, // R1 trigger
        {4'd1, 4'd9, 32'h1234_5678, 4'd9, 32'h0000_0000, 1'b0, 1'b0}  // R1 outside
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] ofs, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = 10'(BASE) + 10'(ofs); wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] ofs, output logic [31:0] q, output logic [31:0] qn);
        sel = 1'b1; we = 1'b0; addr = 10'(BASE) + 10'(ofs);
        #1;
        q = rdata; qn = rdata_nv;
        sel = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] q, qn;
        logic [77:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: every register reads zero after reset.
        for (int o = 0; o < 9; o++) begin
            rd(4'(o), q, qn);
            chk("R10 reset read", q, 32'h0);
        end
        chk("R10 reset outputs", {30'b0, norm, crit}, 32'h0);

        // Table walk over register behaviour.
        for (int i = 0; i < NROW; i++) begin
            e = TBL[i];
            wr(e[73:70], e[69:38]);
            rd(e[37:34], q, qn);
            chk($sformatf("R%0d row %0d read", e[77:74], i), q, e[33:2]);
            chk($sformatf("R%0d row %0d norm", e[77:74], i), {31'b0, norm}, {31'b0, e[1]});
            chk($sformatf("R%0d row %0d crit", e[77:74], i), {31'b0, crit}, {31'b0, e[0]});
        end

        // R9: the copy without vectoring reads zero vector registers.
        wr(4'd1, 32'h0001_0000);
        rd(4'd7, q, qn);
        chk("R9 vector with vectoring", q, 32'h0000_1E00);
        chk("R9 vector without vectoring", qn, 32'h0);
        rd(4'd8, q, qn);
        chk("R9 config without vectoring", qn, 32'h0);
        chk("R9 crit without vectoring", {31'b0, crit_nv}, 32'h1);
        wr(4'd0, 32'h0001_0000);
        chk("R4 clear crit", {31'b0, crit}, 32'h0);

        // R3/R2: line 31 is edge-sensitive (trigger bit 0 set) -> status bit 0.
        wr(4'd2, 32'h0000_0001);
        wr(4'd3, 32'h0000_0000);
        @(negedge clk); src[31] = 1'b1;
        #1 chk("R11 no early output", {31'b0, norm}, 32'h0);
        @(negedge clk);
        rd(4'd0, q, qn);
        chk("R2 R3 edge sets bit 0", q, 32'h0000_0001);
        chk("R11 output after one clock", {31'b0, norm}, 32'h1);
        repeat (2) @(negedge clk);
        wr(4'd0, 32'h0000_0001);
        repeat (2) @(negedge clk);
        rd(4'd0, q, qn);
        chk("R3 held high sets once", q, 32'h0);
        chk("R3 output after clear", {31'b0, norm}, 32'h0);
        src[31] = 1'b0;
        @(negedge clk); src[31] = 1'b1;
        @(negedge clk); src[31] = 1'b0;
        repeat (2) @(negedge clk);
        rd(4'd0, q, qn);
        chk("R3 low input keeps edge bit", q, 32'h0000_0001);
        wr(4'd0, 32'h0000_0001);

        // R4/R2: line 8 is level-sensitive -> status bit 23.
        wr(4'd2, 32'h0080_0000);
        @(negedge clk); src[8] = 1'b1;
        @(negedge clk);
        rd(4'd0, q, qn);
        chk("R2 R4 level sets bit 23", q, 32'h0080_0000);
        chk("R4 level output", {31'b0, norm}, 32'h1);
        wr(4'd0, 32'h0080_0000);
        rd(4'd0, q, qn);
        chk("R4 held level survives clear", q, 32'h0080_0000);
        chk("R4 held level output", {31'b0, norm}, 32'h1);
        @(negedge clk); src[8] = 1'b0;
        @(negedge clk);
        rd(4'd0, q, qn);
        chk("R4 level follows low", q, 32'h0);
        chk("R4 level output low", {31'b0, norm}, 32'h0);

        // R10: reset in mid-run clears the programmed registers.
        wr(4'd8, 32'h3000_0001);
        wr(4'd4, 32'h0000_FFFF);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        rd(4'd8, q, qn); chk("R10 config cleared", q, 32'h0);
        rd(4'd4, q, qn); chk("R10 polarity cleared", q, 32'h0);
        rd(4'd2, q, qn); chk("R10 enable cleared", q, 32'h0);
        rd(4'd5, q, qn); chk("R10 trigger cleared", q, 32'h0);

        finish_run();
    end
endmodule